// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is a memory-mapped SPI master that carries out one flash-style command per trigger. Software writes a command byte into its own register, sets how many data bytes go out after it and how many come back, fills a shared 70-byte buffer with the outgoing data, picks one of four targets, and then writes the start bit. The engine pulls the chosen select line low and shifts out the command byte, then the outgoing buffer bytes, then clocks in the returning bytes. Each returning byte lands in the buffer straight after the last outgoing one.

Shifting is SPI mode 0 with the most significant bit first. The serial clock idles low and moves by one half period on each cycle where `sck_en` is high, so a clock divider outside the block sets the bit rate. A status bit stays set from the accepted start until the select line has been high again for a full serial clock period. While that bit is set, software reads it and must not start another command.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all select lines are high, `sck` is low, the status busy bit (byte 0x4F, bit 7) reads 0, and the command (0x45), send count (0x48) and receive count (0x4B) registers read 0.
- R2: A write with bit 7 set to byte 0x47, made while idle, starts a command. Busy then reads 1 until the command ends. Byte 0x47 always reads 0, because the start bit clears itself.
- R3: On the wire, the command byte goes out first and is followed by buffer bytes 0 to send count minus 1, all MSB first. `sck` idles low and changes only on cycles where `sck_en` is high. `mosi` is stable across each rising edge. There are 8×(1+send+receive) rising edges in total.
- R4: Receive bytes are assembled MSB first from `miso`, which is sampled on rising edges. They are written to buffer positions send count up to send count + receive count − 1. Outgoing bytes and bytes beyond the receive range are left unchanged.
- R5: With both counts at zero, only the command byte is sent: exactly 8 rising edges.
- R6: Bits 1:0 of byte 0x1D choose which `cs_n` line goes low. At most one line is low at any time. Bits 7:2 of that byte are stored and read back unchanged.
- R7: The chosen line goes low before the first rising edge and rises after the last falling edge. Busy stays 1 for two further `sck_en` ticks after the line rises.
- R8: A start write made while busy is ignored: no second command follows.
- R9: A start write is ignored when send count + receive count exceeds 70. Busy stays 0 and no clock edge appears.
- R10: Buffer byte i (0 ≤ i < 70) is read and written at address 0x80+i. Bus writes to the buffer are dropped while busy.
- R11: The command, send count and receive count registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data at `bus_addr` |
| sck_en | input | 1 | Half-period tick for the serial clock |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low select lines |

## Verification
A wrong byte index or bit count in the sequencer shows up at once at the wire. The number of rising edges per select window differs from 8×(1+send+receive), or a captured byte misaligns, and this is visible before busy clears. A wrong receive write address does not show on the pins. It appears only when the buffer is read back after the command, as a returned byte out of place or an outgoing or sentinel byte overwritten. A sweep over all small send and receive count pairs, one maximum-size command and the rejected cases exposes each of these within one command.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BUF_BYTES_DEF = 70;
    localparam int NUM_CS_DEF    = 4;

    localparam logic [7:0] ADDR_CSEL   = 8'h1D;
    localparam logic [7:0] ADDR_OPCODE = 8'h45;
    localparam logic [7:0] ADDR_TRIG   = 8'h47;
    localparam logic [7:0] ADDR_TXCNT  = 8'h48;
    localparam logic [7:0] ADDR_RXCNT  = 8'h4B;
    localparam logic [7:0] ADDR_STATUS = 8'h4F;
    localparam int         ADDR_BUF    = 'h80;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GUARD
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] tx_cnt;
        logic [7:0] rx_cnt;
    } xfer_cfg_t;

    function automatic logic [8:0] total_bytes(xfer_cfg_t c);
        return {1'b0, c.tx_cnt} + {1'b0, c.rx_cnt};
    endfunction

    function automatic logic in_buf_window(logic [7:0] a, int depth);
        return (int'(a) >= ADDR_BUF) && (int'(a) < ADDR_BUF + depth);
    endfunction

endpackage

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
    parameter int DEPTH = 70,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [7:0]       rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [7:0]       rd_data_b
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data_a = (int'(rd_idx_a) < DEPTH) ? mem_q[rd_idx_a] : 8'h00;
        rd_data_b = (int'(rd_idx_b) < DEPTH) ? mem_q[rd_idx_b] : 8'h00;
    end

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES = 70
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       busy,
    output xfer_cfg_t  cfg,
    output logic [7:0] csel_raw,
    output logic       start
);

    xfer_cfg_t  cfg_q;
    logic [7:0] csel_q;
    logic       fits;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            csel_q <= 8'h00;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADDR_OPCODE: cfg_q.opcode <= bus_wdata;
                ADDR_TXCNT:  cfg_q.tx_cnt <= bus_wdata;
                ADDR_RXCNT:  cfg_q.rx_cnt <= bus_wdata;
                ADDR_CSEL:   csel_q       <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign fits     = total_bytes(cfg_q) <= 9'(BUF_BYTES);
    assign start    = bus_wr && (bus_addr == ADDR_TRIG) && bus_wdata[7] && !busy && fits;
    assign cfg      = cfg_q;
    assign csel_raw = csel_q;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES   = 70,
    parameter int NUM_CS      = 4,
    parameter int GUARD_TICKS = 2,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int GC_W  = $clog2(GUARD_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cfg_t         cfg_in,
    input  logic [CS_W-1:0]   cs_idx_in,
    input  logic              sck_en,
    input  logic              miso,
    output logic [IDX_W-1:0]  buf_rd_idx,
    input  logic [7:0]        buf_rd_data,
    output logic              buf_wr_en,
    output logic [IDX_W-1:0]  buf_wr_idx,
    output logic [7:0]        buf_wr_data,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n
);

    seq_state_e      state_q;
    xfer_cfg_t       cfg_q;
    logic [CS_W-1:0] cs_idx_q;
    logic [7:0]      tx_sh_q;
    logic [7:0]      rx_sh_q;
    logic [2:0]      bit_q;
    logic [7:0]      byte_q;
    logic            opc_q;
    logic            sck_q;
    logic            cs_act_q;
    logic [GC_W-1:0] guard_q;

    logic [8:0] total;
    logic [7:0] next_byte;
    logic       last_byte;
    logic       in_rx;
    logic       byte_end;
    logic [7:0] next_tx;

    always_comb begin
        total      = total_bytes(cfg_q);
        next_byte  = opc_q ? 8'd0 : byte_q + 8'd1;
        last_byte  = opc_q ? (total == 9'd0) : ({1'b0, next_byte} == total);
        in_rx      = !opc_q && (byte_q >= cfg_q.tx_cnt);
        byte_end   = (state_q == ST_SHIFT) && sck_en && sck_q && (bit_q == 3'd7);
        next_tx    = (next_byte < cfg_q.tx_cnt) ? buf_rd_data : 8'h00;
    end

    assign buf_rd_idx  = next_byte[IDX_W-1:0];
    assign buf_wr_en   = byte_end && in_rx;
    assign buf_wr_idx  = byte_q[IDX_W-1:0];
    assign buf_wr_data = rx_sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            cs_idx_q <= '0;
            tx_sh_q  <= 8'h00;
            rx_sh_q  <= 8'h00;
            bit_q    <= 3'd0;
            byte_q   <= 8'd0;
            opc_q    <= 1'b0;
            sck_q    <= 1'b0;
            cs_act_q <= 1'b0;
            guard_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q    <= cfg_in;
                        cs_idx_q <= cs_idx_in;
                        tx_sh_q  <= cfg_in.opcode;
                        bit_q    <= 3'd0;
                        byte_q   <= 8'd0;
                        opc_q    <= 1'b1;
                        sck_q    <= 1'b0;
                        cs_act_q <= 1'b1;
                        state_q  <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sck_en) begin
                        if (!sck_q) begin
                            sck_q   <= 1'b1;
                            rx_sh_q <= {rx_sh_q[6:0], miso};
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_q == 3'd7) begin
                                if (last_byte) begin
                                    cs_act_q <= 1'b0;
                                    guard_q  <= '0;
                                    state_q  <= ST_GUARD;
                                end else begin
                                    opc_q   <= 1'b0;
                                    byte_q  <= next_byte;
                                    tx_sh_q <= next_tx;
                                    bit_q   <= 3'd0;
                                end
                            end else begin
                                bit_q   <= bit_q + 3'd1;
                                tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                            end
                        end
                    end
                end
                ST_GUARD: begin
                    if (sck_en) begin
                        if (guard_q == GC_W'(GUARD_TICKS - 1)) begin
                            state_q <= ST_IDLE;
                        end else begin
                            guard_q <= guard_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign sck  = sck_q;
    assign mosi = cs_act_q ? tx_sh_q[7] : 1'b0;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(cs_act_q && (cs_idx_q == CS_W'(g)));
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES   = BUF_BYTES_DEF,
    parameter int NUM_CS      = NUM_CS_DEF,
    parameter int GUARD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sck_en,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int CS_W  = $clog2(NUM_CS);

    xfer_cfg_t        cfg;
    logic [7:0]       csel_raw;
    logic             start;
    logic             busy_w;
    logic             is_buf;
    logic [7:0]       buf_off;
    logic [IDX_W-1:0] eng_rd_idx;
    logic [7:0]       eng_rd_data;
    logic             eng_wr_en;
    logic [IDX_W-1:0] eng_wr_idx;
    logic [7:0]       eng_wr_data;
    logic [7:0]       bus_buf_data;
    logic             mem_wr_en;
    logic [IDX_W-1:0] mem_wr_idx;
    logic [7:0]       mem_wr_data;

    assign is_buf  = in_buf_window(bus_addr, BUF_BYTES);
    assign buf_off = bus_addr - 8'(ADDR_BUF);

    spi_cmd_regs #(.BUF_BYTES(BUF_BYTES)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .busy     (busy_w),
        .cfg      (cfg),
        .csel_raw (csel_raw),
        .start    (start)
    );

    spi_cmd_seq #(
        .BUF_BYTES  (BUF_BYTES),
        .NUM_CS     (NUM_CS),
        .GUARD_TICKS(GUARD_TICKS)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_in     (cfg),
        .cs_idx_in  (csel_raw[CS_W-1:0]),
        .sck_en     (sck_en),
        .miso       (miso),
        .buf_rd_idx (eng_rd_idx),
        .buf_rd_data(eng_rd_data),
        .buf_wr_en  (eng_wr_en),
        .buf_wr_idx (eng_wr_idx),
        .buf_wr_data(eng_wr_data),
        .busy       (busy_w),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n)
    );

    always_comb begin
        if (eng_wr_en) begin
            mem_wr_en   = 1'b1;
            mem_wr_idx  = eng_wr_idx;
            mem_wr_data = eng_wr_data;
        end else begin
            mem_wr_en   = bus_wr && is_buf && !busy_w;
            mem_wr_idx  = buf_off[IDX_W-1:0];
            mem_wr_data = bus_wdata;
        end
    end

    spi_cmd_buffer #(.DEPTH(BUF_BYTES)) buf_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (mem_wr_en),
        .wr_idx   (mem_wr_idx),
        .wr_data  (mem_wr_data),
        .rd_idx_a (eng_rd_idx),
        .rd_data_a(eng_rd_data),
        .rd_idx_b (buf_off[IDX_W-1:0]),
        .rd_data_b(bus_buf_data)
    );

    always_comb begin
        if (is_buf) begin
            bus_rdata = bus_buf_data;
        end else begin
            unique case (bus_addr)
                ADDR_OPCODE: bus_rdata = cfg.opcode;
                ADDR_TXCNT:  bus_rdata = cfg.tx_cnt;
                ADDR_RXCNT:  bus_rdata = cfg.rx_cnt;
                ADDR_CSEL:   bus_rdata = csel_raw;
                ADDR_STATUS: bus_rdata = {busy_w, 7'b0};
                default:     bus_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
    import spi_cmd_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              sck_en,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              busy
);

    logic trig_wr;
    assign trig_wr = bus_wr && (bus_addr == ADDR_TRIG) && bus_wdata[7];

    p_cs_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    p_cs_within_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (cs_n != '1) |-> busy);

    p_release_guard_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(&cs_n) |-> busy);

    p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    p_sck_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !sck_en |=> $stable(sck));

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(mosi));

    p_start_from_trigger_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig_wr));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sck_en   (sck_en),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .busy     (busy_w)
);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 70;
    localparam logic [7:0] A_CSEL = 8'h1D, A_OPC = 8'h45, A_TRIG = 8'h47,
                           A_TX = 8'h48, A_RX = 8'h4B, A_STAT = 8'h4F, A_BUF = 8'h80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_en = 1'b0;
    logic       sck, mosi, miso;
    logic [3:0] cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // slave model state
    int         rise_cnt = 0;
    int         stray_rise = 0;
    int         seed = 0;
    logic [7:0] mosi_cap [0:127];
    bit [3:0]   seen_low;
    int         cyc = 0;
    int         cs_rel_cycle = -1;
    int         busy_clr_cycle = -1;
    bit         cs_was_low = 0;
    logic [7:0] sb;

    spi_cmd_engine dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_en(sck_en),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] slave_byte(int b, int s);
        return 8'(b * 29 + s * 11 + 3);
    endfunction

    function automatic logic [7:0] tx_byte(int i, int s);
        return 8'(i * 13 + s * 7 + 1);
    endfunction

    always_comb begin
        sb   = slave_byte(rise_cnt / 8, seed);
        miso = sb[7 - (rise_cnt % 8)];
    end

    always @(posedge sck) begin
        if (cs_n != 4'hF) begin
            if (rise_cnt < 1024) mosi_cap[(rise_cnt / 8) % 128][7 - (rise_cnt % 8)] = mosi;
            rise_cnt = rise_cnt + 1;
        end else begin
            stray_rise = stray_rise + 1;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        sck_en <= ~sck_en;
        for (int i = 0; i < 4; i++) if (!cs_n[i]) seen_low[i] = 1'b1;
        if (cs_was_low && (&cs_n)) cs_rel_cycle = cyc;
        cs_was_low = !(&cs_n);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int n = 0;
        do begin
            bus_read(A_STAT, s);
            n++;
        end while (s[7] && n < 20000);
        busy_clr_cycle = cyc;
    endtask

    task automatic run_xfer(input int opc, input int tx, input int rx, input int cs,
                            input int sd, input bit poke);
        logic [7:0] d;
        int total = tx + rx;
        seed = sd;
        bus_write(A_OPC, 8'(opc));
        bus_write(A_TX, 8'(tx));
        bus_write(A_RX, 8'(rx));
        bus_write(A_CSEL, {6'h2B, 2'(cs)});
        for (int i = 0; i < tx; i++) bus_write(A_BUF + 8'(i), tx_byte(i, sd));
        if (total < DEPTH - 1) begin
            bus_write(A_BUF + 8'(total), 8'hEE);
            bus_write(A_BUF + 8'(DEPTH - 1), 8'h77);
        end
        rise_cnt = 0; stray_rise = 0; seen_low = '0; cs_rel_cycle = -1;
        bus_write(A_TRIG, 8'h80);
        bus_read(A_STAT, d);
        check(d[7] == 1'b1, "R2 busy after start", int'(d[7]), 1);
        bus_read(A_TRIG, d);
        check(d == 8'h00, "R2 start bit self-clears", int'(d), 0);
        if (total < DEPTH - 1) bus_write(A_BUF + 8'(DEPTH - 1), 8'h33);
        if (poke) bus_write(A_TRIG, 8'h80);
        wait_idle();
        if (poke) begin
            repeat (400) @(negedge clk);
        end
        check(rise_cnt == 8 * (1 + total), (total == 0) ? "R5 opcode-only edges" : "R3 edge count",
              rise_cnt, 8 * (1 + total));
        check(stray_rise == 0, "R7 no edge outside select", stray_rise, 0);
        check(mosi_cap[0] == 8'(opc), "R3 opcode first", int'(mosi_cap[0]), opc);
        for (int i = 0; i < tx; i++)
            check(mosi_cap[1 + i] == tx_byte(i, sd), "R3 send byte", int'(mosi_cap[1 + i]),
                  int'(tx_byte(i, sd)));
        for (int j = 0; j < rx; j++) begin
            bus_read(A_BUF + 8'(tx + j), d);
            check(d == slave_byte(1 + tx + j, sd), "R4 receive byte placement", int'(d),
                  int'(slave_byte(1 + tx + j, sd)));
        end
        for (int i = 0; i < tx; i++) begin
            bus_read(A_BUF + 8'(i), d);
            check(d == tx_byte(i, sd), "R4 send bytes kept", int'(d), int'(tx_byte(i, sd)));
        end
        if (total < DEPTH - 1) begin
            bus_read(A_BUF + 8'(total), d);
            check(d == 8'hEE, "R4 byte past receive range kept", int'(d), 'hEE);
            bus_read(A_BUF + 8'(DEPTH - 1), d);
            check(d == 8'h77, "R10 buffer write while busy dropped", int'(d), 'h77);
        end
        check(seen_low == (4'b0001 << cs), "R6 select line", int'(seen_low), int'(4'b0001 << cs));
        check(cs_n == 4'hF, "R7 select released", int'(cs_n), 15);
        check(cs_rel_cycle >= 0 && busy_clr_cycle - cs_rel_cycle >= 2, "R7 guard after release",
              busy_clr_cycle - cs_rel_cycle, 2);
        if (poke) check(rise_cnt == 8 * (1 + total), "R8 start while busy ignored", rise_cnt,
                        8 * (1 + total));
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(cs_n == 4'hF, "R1 selects high", int'(cs_n), 15);
        check(sck == 1'b0, "R1 sck low", int'(sck), 0);
        bus_read(A_STAT, d); check(d[7] == 1'b0, "R1 busy clear", int'(d[7]), 0);
        bus_read(A_OPC, d);  check(d == 8'h00, "R1 command reg", int'(d), 0);
        bus_read(A_TX, d);   check(d == 8'h00, "R1 send count", int'(d), 0);
        bus_read(A_RX, d);   check(d == 8'h00, "R1 receive count", int'(d), 0);
        // R11 readback, R6 upper bits, R10 buffer access
        bus_write(A_OPC, 8'hC3); bus_read(A_OPC, d); check(d == 8'hC3, "R11 command readback", int'(d), 'hC3);
        bus_write(A_TX, 8'h21);  bus_read(A_TX, d);  check(d == 8'h21, "R11 send count readback", int'(d), 'h21);
        bus_write(A_RX, 8'h14);  bus_read(A_RX, d);  check(d == 8'h14, "R11 receive count readback", int'(d), 'h14);
        bus_write(A_CSEL, 8'hA6); bus_read(A_CSEL, d); check(d == 8'hA6, "R6 select byte readback", int'(d), 'hA6);
        bus_write(A_BUF + 8'(DEPTH - 1), 8'h5C); bus_read(A_BUF + 8'(DEPTH - 1), d);
        check(d == 8'h5C, "R10 last buffer byte", int'(d), 'h5C);
        // R9 oversize start ignored
        bus_write(A_TX, 8'd40); bus_write(A_RX, 8'd31);
        rise_cnt = 0; stray_rise = 0;
        bus_write(A_TRIG, 8'h80);
        bus_read(A_STAT, d); check(d[7] == 1'b0, "R9 oversize not started", int'(d[7]), 0);
        repeat (40) @(negedge clk);
        check(rise_cnt + stray_rise == 0, "R9 no clock edges", rise_cnt + stray_rise, 0);
        check(cs_n == 4'hF, "R9 selects stay high", int'(cs_n), 15);
        // sweep of small count pairs
        for (int tx = 0; tx <= 4; tx++)
            for (int rx = 0; rx <= 4; rx++)
                run_xfer(8'h03 + tx * 16 + rx, tx, rx, (tx + rx) % 4, tx * 5 + rx, tx == 2 && rx == 2);
        // full buffer
        run_xfer(8'h9F, 40, 30, 1, 9, 1'b0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule